// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This unit owns the 16-bit program counter and the 16-bit stack pointer of a small byte-oriented processor. It carries out the control-flow instructions: jump, call and return in conditional and unconditional forms, restart, and loading the program counter from the HL register pair. The surrounding core supplies a start strobe, the opcode, the four condition flags and the HL value. The unit then runs one or more byte transfers over its own memory port, which has a request/ready handshake.

Address operands are fetched from the two bytes that follow the opcode, low byte first. Calls and restarts push a return address onto the stack as two byte writes. Returns pop that address back as two byte reads. When an instruction finishes, the unit gives a one-cycle done pulse, and the program counter output holds the new value.

The core's other duties are outside this unit: fetching opcodes that do not branch, the ALU, and interrupt handling. The program counter is assumed to point at the opcode when start is raised.

Top module: `pc_stack_seq`

## Requirements
- R1: After reset, pc_out equals PC_INIT (default 0x0100), sp_out equals SP_INIT (default 0x0F00), and busy, done and mem_req are all low. No memory request is made while the unit is idle.
- R2: A jump reads the low target byte at PC+1 and then the high target byte at PC+2. When the jump is taken, the program counter becomes {high, low}. The unconditional jump is 0xC3 and the conditional jump is binary 11ccc010.
- R3: The 3-bit condition field ccc sits in opcode bits 5:3 and is shared by jump, call and return. Its codes are: 000 zero flag clear, 001 zero flag set, 010 carry clear, 011 carry set, 100 parity flag clear, 101 parity flag set, 110 sign clear, 111 sign set. A false condition on a jump or a call still reads both address bytes, makes no stack write, and leaves PC+3.
- R4: A taken call (0xCD unconditional, 11ccc100 conditional) writes the high byte of PC+3 at SP-1, then the low byte at SP-2. It then leaves SP decreased by 2 and loads the target into the program counter.
- R5: A return (0xC9 unconditional, 11ccc000 conditional) reads the low byte at SP and the high byte at SP+1, loads {high, low} into the program counter, and leaves SP increased by 2. A false conditional return makes no memory transfer and leaves PC+1.
- R6: Restart 11nnn111 pushes PC+1 in the same way as a call and loads the program counter with nnn times 8.
- R7: Opcode 0xE9 copies hl_val into the program counter in one cycle, with no memory transfer.
- R8: done is high for exactly one cycle as each instruction completes. busy is low in that cycle, and pc_out already shows the final value.
- R9: While mem_req is high and mem_rdy is low, mem_addr, mem_we, mem_wdata, pc_out and sp_out hold their values, and the request stays raised.
- R10: start is ignored while busy is high.
- R11: Any opcode that is not a control-flow opcode completes with done in the following cycle. It leaves PC and SP unchanged and makes no memory transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin executing the opcode that is presented |
| opcode | input | 8 | Instruction byte, sampled when start is accepted |
| flag_zero | input | 1 | Zero flag, sampled with start |
| flag_carry | input | 1 | Carry flag, sampled with start |
| flag_parity | input | 1 | Parity flag (1 means even), sampled with start |
| flag_sign | input | 1 | Sign flag, sampled with start |
| hl_val | input | 16 | HL register pair value |
| busy | output | 1 | A multi-cycle instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Program counter |
| sp_out | output | 16 | Stack pointer |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 means write, 0 means read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle where mem_req and mem_rdy are both high |
| mem_rdy | input | 1 | Memory accepts the transfer this cycle |

## Verification
Two things can fall in the same cycle: a new start request, and a pending stack transfer that memory is stalling. To provoke this, the bench holds start high for the whole of a call and of a return while mem_rdy alternates every cycle. It drops start only on the cycle where done is seen. The result is judged by the exact number of memory transfers, the bytes left on the stack, and the final PC and SP. An accepted second start, or a step that moved forward during a stall, would change those numbers.

// File: rtl/pcs_pkg.sv
// Package: shared types for the program counter and stack sequencer.
// Assumes byte-wide memory and 16-bit addresses.
package pcs_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    // Instruction class, as recognised by the decoder
    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_JMP,
        CLS_CALL,
        CLS_RET,
        CLS_RST,
        CLS_PCHL
    } op_cls_e;

    // Sequencer steps
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPLO,
        ST_OPHI,
        ST_PUSHH,
        ST_PUSHL,
        ST_POPL,
        ST_POPH
    } seq_st_e;

    typedef struct packed {
        op_cls_e    cls;
        logic       uncond;
        logic [2:0] cc;
        logic [2:0] vec;
    } dec_t;
endpackage

// File: rtl/pcs_decode.sv
// Module: pcs_decode
// Purely combinational classification of an opcode into a control-flow class.
// It also extracts the condition field and the restart vector.
// Assumes the opcode layout 11 xxx yyy for every control-flow instruction.
module pcs_decode
    import pcs_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output dec_t              dec
);
    logic [1:0] top2;
    logic [2:0] mid3;
    logic [2:0] low3;

    assign top2 = op[7:6];
    assign mid3 = op[5:3];
    assign low3 = op[2:0];

    // Map the opcode fields to a class
    always_comb begin
        dec.cls    = CLS_NONE;
        dec.uncond = 1'b0;
        dec.cc     = mid3;
        dec.vec    = mid3;
        if (top2 == 2'b11) begin
            unique case (low3)
                3'b010: dec.cls = CLS_JMP;
                3'b011: if (mid3 == 3'b000) begin
                            dec.cls    = CLS_JMP;
                            dec.uncond = 1'b1;
                        end
                3'b100: dec.cls = CLS_CALL;
                3'b101: if (mid3 == 3'b001) begin
                            dec.cls    = CLS_CALL;
                            dec.uncond = 1'b1;
                        end
                3'b000: dec.cls = CLS_RET;
                3'b001: if (mid3 == 3'b001) begin
                            dec.cls    = CLS_RET;
                            dec.uncond = 1'b1;
                        end else if (mid3 == 3'b101) begin
                            dec.cls = CLS_PCHL;
                        end
                3'b111: dec.cls = CLS_RST;
                default: dec.cls = CLS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pcs_cond.sv
// Module: pcs_cond
// Evaluates the shared 3-bit condition field against the flags.
// cc[2:1] selects the flag and cc[0] gives the value the flag must have.
// Unconditional forms are always taken.
module pcs_cond (
    input  logic [2:0] cc,
    input  logic       uncond,
    input  logic       zf,
    input  logic       cf,
    input  logic       pf,
    input  logic       sf,
    output logic       take
);
    logic sel_flag;

    // Pick the flag named by the condition field
    always_comb begin
        unique case (cc[2:1])
            2'd0:    sel_flag = zf;
            2'd1:    sel_flag = cf;
            2'd2:    sel_flag = pf;
            default: sel_flag = sf;
        endcase
    end

    assign take = uncond | (sel_flag == cc[0]);
endmodule

// File: rtl/pcs_memport.sv
// Module: pcs_memport
// Drives the byte memory request from the current sequencer step.
// Operand reads go to PC+1 and PC+2. Pushes go to SP-1. Pops go to SP.
module pcs_memport
    import pcs_pkg::*;
(
    input  seq_st_e           st,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] ret,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] wdata
);
    // Choose request, direction, address and data for each step
    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        unique case (st)
            ST_OPLO:  addr = pc + ADDR_W'(1);
            ST_OPHI:  addr = pc + ADDR_W'(2);
            ST_PUSHH: begin
                we    = 1'b1;
                addr  = sp - ADDR_W'(1);
                wdata = ret[ADDR_W-1:BYTE_W];
            end
            ST_PUSHL: begin
                we    = 1'b1;
                addr  = sp - ADDR_W'(1);
                wdata = ret[BYTE_W-1:0];
            end
            ST_POPL, ST_POPH: addr = sp;
            default: req = 1'b0;
        endcase
    end
endmodule

// File: rtl/pc_stack_seq.sv
// Module: pc_stack_seq (top)
// Owns PC and SP. Executes jump, call, return, restart and load-PC-from-HL
// over a byte memory port with a request/ready handshake.
// Assumes PC points at the opcode when start is accepted. Flags and HL are
// sampled in the accept cycle. The whole unit holds while mem_rdy is low.
module pc_stack_seq
    import pcs_pkg::*;
#(
    parameter logic [15:0] PC_INIT = 16'h0100,
    parameter logic [15:0] SP_INIT = 16'h0F00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  opcode,
    input  logic        flag_zero,
    input  logic        flag_carry,
    input  logic        flag_parity,
    input  logic        flag_sign,
    input  logic [15:0] hl_val,
    output logic        busy,
    output logic        done,
    output logic [15:0] pc_out,
    output logic [15:0] sp_out,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    input  logic        mem_rdy
);
    localparam int VEC_SHIFT = 3;
    localparam int VEC_PAD   = ADDR_W - 3 - VEC_SHIFT;

    seq_st_e           st_q;
    op_cls_e           cls_q;
    logic              take_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [ADDR_W-1:0] ret_q;
    logic              done_q;

    dec_t dec;
    logic take;
    logic xfer;

    pcs_decode u_dec (
        .op  (opcode),
        .dec (dec)
    );

    pcs_cond u_cond (
        .cc     (dec.cc),
        .uncond (dec.uncond),
        .zf     (flag_zero),
        .cf     (flag_carry),
        .pf     (flag_parity),
        .sf     (flag_sign),
        .take   (take)
    );

    pcs_memport u_mem (
        .st    (st_q),
        .pc    (pc_q),
        .sp    (sp_q),
        .ret   (ret_q),
        .req   (mem_req),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    assign xfer = mem_req & mem_rdy;

    // Sequencer: steps through operand fetch, push and pop, and commits PC/SP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cls_q  <= CLS_NONE;
            take_q <= 1'b0;
            pc_q   <= PC_INIT;
            sp_q   <= SP_INIT;
            tgt_q  <= '0;
            ret_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        cls_q  <= dec.cls;
                        take_q <= take;
                        unique case (dec.cls)
                            CLS_JMP, CLS_CALL: st_q <= ST_OPLO;
                            CLS_RET: begin
                                if (take) begin
                                    st_q <= ST_POPL;
                                end else begin
                                    pc_q   <= pc_q + ADDR_W'(1);
                                    done_q <= 1'b1;
                                end
                            end
                            CLS_RST: begin
                                ret_q <= pc_q + ADDR_W'(1);
                                tgt_q <= {{VEC_PAD{1'b0}}, dec.vec, {VEC_SHIFT{1'b0}}};
                                st_q  <= ST_PUSHH;
                            end
                            CLS_PCHL: begin
                                pc_q   <= hl_val;
                                done_q <= 1'b1;
                            end
                            default: done_q <= 1'b1;
                        endcase
                    end
                end
                ST_OPLO: begin
                    if (xfer) begin
                        tgt_q[BYTE_W-1:0] <= mem_rdata;
                        st_q              <= ST_OPHI;
                    end
                end
                ST_OPHI: begin
                    if (xfer) begin
                        if (!take_q) begin
                            pc_q   <= pc_q + ADDR_W'(3);
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else if (cls_q == CLS_JMP) begin
                            pc_q   <= {mem_rdata, tgt_q[BYTE_W-1:0]};
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            tgt_q[ADDR_W-1:BYTE_W] <= mem_rdata;
                            ret_q                  <= pc_q + ADDR_W'(3);
                            st_q                   <= ST_PUSHH;
                        end
                    end
                end
                ST_PUSHH: begin
                    if (xfer) begin
                        sp_q <= sp_q - ADDR_W'(1);
                        st_q <= ST_PUSHL;
                    end
                end
                ST_PUSHL: begin
                    if (xfer) begin
                        sp_q   <= sp_q - ADDR_W'(1);
                        pc_q   <= tgt_q;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                ST_POPL: begin
                    if (xfer) begin
                        tgt_q[BYTE_W-1:0] <= mem_rdata;
                        sp_q              <= sp_q + ADDR_W'(1);
                        st_q              <= ST_POPH;
                    end
                end
                ST_POPH: begin
                    if (xfer) begin
                        pc_q   <= {mem_rdata, tgt_q[BYTE_W-1:0]};
                        sp_q   <= sp_q + ADDR_W'(1);
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (st_q != ST_IDLE);
    assign done   = done_q;
    assign pc_out = pc_q;
    assign sp_out = sp_q;
endmodule

// File: rtl/pcs_checker.sv
// Module: pcs_checker
// Temporal checks on the sequencer ports. Attached to every pc_stack_seq by bind.
module pcs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_rdy,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic [15:0] pc_out,
    input logic [15:0] sp_out
);
    // R1: no memory request while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R8: the completion pulse comes only with the unit back in idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: a stalled request keeps its address, direction and data
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R9: a stall freezes PC and SP
    a_r9_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> ($stable(pc_out) && $stable(sp_out)));

    // R4: each accepted stack write moves SP down by one
    a_r4_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_rdy) |=> (sp_out == $past(sp_out) - 16'd1));
endmodule

bind pc_stack_seq pcs_checker u_pcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_rdy   (mem_rdy),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_out    (pc_out),
    .sp_out    (sp_out)
);

// File: tb/pc_stack_seq_bench.sv
`timescale 1ns/1ps
// Directed bench: the memory model, one task per scenario, and self-checks.
module pc_stack_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        zf = 1'b0, cf = 1'b0, pf = 1'b0, sf = 1'b0;
    logic [15:0] hl = 16'h0000;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] pc_out, sp_out, mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        rdy_q = 1'b1;
    logic        stall_en = 1'b0;

    logic [7:0] mem [0:4095];
    int total = 0;
    int bad = 0;
    int xfers = 0;
    int writes = 0;
    bit finished = 0;
    logic [15:0] exp_pc = 16'h0100;
    logic [15:0] exp_sp = 16'h0F00;

    always #2.5 clk = ~clk;

    pc_stack_seq u_pc_stack_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .flag_zero(zf), .flag_carry(cf), .flag_parity(pf), .flag_sign(sf),
        .hl_val(hl), .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(rdy_q)
    );

    assign mem_rdata = mem[mem_addr[11:0]];

    // Memory model: counts transfers and performs writes
    always @(posedge clk) begin
        if (rst_n && mem_req && rdy_q) begin
            xfers = xfers + 1;
            if (mem_we) begin
                mem[mem_addr[11:0]] = mem_wdata;
                writes = writes + 1;
            end
        end
    end

    // Ready pattern: always ready, or alternating when stalls are on
    always @(negedge clk) rdy_q <= stall_en ? ~rdy_q : 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one opcode, wait for done, and check the pulse and PC/SP
    task automatic issue(input string req, input logic [7:0] op, input bit hold);
        bit got = 0;
        @(negedge clk);
        opcode = op;
        start  = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!hold) start = 1'b0;
            if (done) begin got = 1; break; end
        end
        start = 1'b0;
        chk({req, " done seen"}, {31'd0, got}, 32'd1);
        chk({req, " pc"}, {16'd0, pc_out}, {16'd0, exp_pc});
        chk({req, " sp"}, {16'd0, sp_out}, {16'd0, exp_sp});
        @(negedge clk);
        chk("R8 single pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic put_ops(input logic [15:0] at, input logic [15:0] tgt);
        mem[at[11:0] + 12'd1] = tgt[7:0];
        mem[at[11:0] + 12'd2] = tgt[15:8];
    endtask

    task automatic t_reset;
        chk("R1 pc", {16'd0, pc_out}, 32'h0100);
        chk("R1 sp", {16'd0, sp_out}, 32'h0F00);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 req", {31'd0, mem_req}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
    endtask

    task automatic t_jump;
        int x0 = xfers;
        put_ops(exp_pc, 16'h0234);
        exp_pc = 16'h0234;
        issue("R2 jmp", 8'hC3, 0);
        chk("R2 two reads", xfers - x0, 32'd2);
    endtask

    // All eight condition codes, each true once and false once
    task automatic t_cond_jumps;
        for (int c = 0; c < 8; c++) begin
            for (int t = 0; t < 2; t++) begin
                logic [2:0] cc = 3'(c);
                logic val = (t == 1) ? cc[0] : ~cc[0];
                logic [15:0] tgt = 16'h0300 + 16'(c * 16 + t * 8);
                int w0 = writes;
                zf = ~val; cf = ~val; pf = ~val; sf = ~val;
                case (cc[2:1])
                    2'd0: zf = val;
                    2'd1: cf = val;
                    2'd2: pf = val;
                    default: sf = val;
                endcase
                put_ops(exp_pc, tgt);
                exp_pc = (t == 1) ? tgt : exp_pc + 16'd3;
                issue("R3 cond jump", {2'b11, cc, 3'b010}, 0);
                chk("R3 no writes", writes - w0, 32'd0);
            end
        end
    endtask

    task automatic t_call;
        int x0 = xfers;
        logic [15:0] ra = exp_pc + 16'd3;
        put_ops(exp_pc, 16'h0500);
        exp_pc = 16'h0500;
        exp_sp = exp_sp - 16'd2;
        issue("R4 call", 8'hCD, 0);
        chk("R4 transfers", xfers - x0, 32'd4);
        chk("R4 high byte", {24'd0, mem[exp_sp[11:0] + 12'd1]}, {24'd0, ra[15:8]});
        chk("R4 low byte", {24'd0, mem[exp_sp[11:0]]}, {24'd0, ra[7:0]});
    endtask

    task automatic t_call_not_taken;
        int x0 = xfers;
        int w0 = writes;
        zf = 1'b0;
        put_ops(exp_pc, 16'h0777);
        exp_pc = exp_pc + 16'd3;
        issue("R3 call not taken", 8'hCC, 0);
        chk("R3 call nt reads", xfers - x0, 32'd2);
        chk("R3 call nt writes", writes - w0, 32'd0);
    endtask

    task automatic t_ret_not_taken;
        int x0 = xfers;
        cf = 1'b0;
        exp_pc = exp_pc + 16'd1;
        issue("R5 ret not taken", 8'hD8, 0);
        chk("R5 ret nt no traffic", xfers - x0, 32'd0);
    endtask

    task automatic t_ret(input string req, input bit hold);
        int x0 = xfers;
        exp_pc = {mem[exp_sp[11:0] + 12'd1], mem[exp_sp[11:0]]};
        exp_sp = exp_sp + 16'd2;
        issue(req, 8'hC9, hold);
        chk({req, " transfers"}, xfers - x0, 32'd2);
    endtask

    task automatic t_restart;
        logic [15:0] ra = exp_pc + 16'd1;
        exp_pc = 16'h0028;
        exp_sp = exp_sp - 16'd2;
        issue("R6 rst", 8'hEF, 0);
        chk("R6 pushed high", {24'd0, mem[exp_sp[11:0] + 12'd1]}, {24'd0, ra[15:8]});
        chk("R6 pushed low", {24'd0, mem[exp_sp[11:0]]}, {24'd0, ra[7:0]});
    endtask

    task automatic t_pchl;
        int x0 = xfers;
        hl = 16'h0ABC;
        exp_pc = 16'h0ABC;
        issue("R7 pchl", 8'hE9, 0);
        chk("R7 no traffic", xfers - x0, 32'd0);
    endtask

    task automatic t_other;
        int x0 = xfers;
        issue("R11 nop", 8'h00, 0);
        issue("R11 other", 8'h3E, 0);
        chk("R11 no traffic", xfers - x0, 32'd0);
    endtask

    // Start held through a stalled call and a stalled return
    task automatic t_stall_busy;
        int x0 = xfers;
        logic [15:0] ra = exp_pc + 16'd3;
        stall_en = 1'b1;
        put_ops(exp_pc, 16'h0600);
        exp_pc = 16'h0600;
        exp_sp = exp_sp - 16'd2;
        issue("R10 held call", 8'hCD, 1);
        chk("R9 R10 call transfers", xfers - x0, 32'd4);
        chk("R9 stalled low byte", {24'd0, mem[exp_sp[11:0]]}, {24'd0, ra[7:0]});
        t_ret("R10 held ret", 1);
        stall_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_jump();
        t_cond_jumps();
        t_call();
        t_call_not_taken();
        t_ret_not_taken();
        t_ret("R5 ret", 0);
        t_restart();
        t_pchl();
        t_other();
        t_stall_busy();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule